// File: doc/BRIEF.md
# Track Candidate Selector

This block sits after a track fitter and reduces the stream of fitted track candidates of one region of interest to a single chosen candidate. Each candidate carries an unsigned transverse momentum, a chi-square figure and a flag from the fitter that says the fit converged. Candidates with a bad fit or a chi-square above a fixed quality limit are discarded. The others are folded into running state as they arrive, so no candidate list is ever stored.

When the upstream logic marks the end of a region, the block emits one result a cycle later. The result holds the chosen candidate's momentum and chi-square, a no-candidate flag and a trigger bit. The trigger bit is high when the chosen momentum reaches a programmable threshold. A two-bit strategy input picks one of three ways to choose the candidate: the largest momentum, the smallest chi-square, or the larger momentum of the two smallest-chi-square candidates. Running state clears as the region closes, so a new region may begin in the very next cycle.

Top module: `trk_cand_sel`

## Requirements
- R1: After reset, and until the first region closes, `res_vld`, `res_trig` and `res_none` are low.
- R2: A candidate takes part in selection only when `cand_vld` and `cand_fit_ok` are both high and `cand_chi2` is at most CHI_MAX (default 40). A chi-square of 40 qualifies and 41 does not.
- R3: With `sel_mode` 0 or 3, the qualifying candidate with the largest `cand_pt` is chosen. When momenta are equal, the earlier arrival wins.
- R4: With `sel_mode` 2, the qualifying candidate with the smallest `cand_chi2` is chosen. When chi-squares are equal, the earlier arrival wins.
- R5: With `sel_mode` 1, the two qualifying candidates with the smallest chi-square are kept, the earlier arrival winning chi-square ties. Of these two, the one with the larger momentum is chosen. On equal momentum the one with the smaller chi-square is chosen. A lone qualifying candidate is chosen directly.
- R6: `res_vld` is high for exactly the cycle after a cycle with `region_end` high and is low otherwise. While it is high, `res_pt` and `res_chi2` carry the chosen candidate.
- R7: `res_trig` equals (chosen momentum >= `pt_cut`). Both `pt_cut` and `sel_mode` are taken in the `region_end` cycle.
- R8: When no qualifying candidate arrived in the region, the result has `res_none` high, `res_trig` low, and `res_pt` and `res_chi2` zero.
- R9: A candidate presented in the same cycle as `region_end` belongs to the region that is closing. The next region starts empty in the following cycle, with no idle cycle required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_vld | input | 1 | Candidate present this cycle |
| cand_pt | input | 16 | Candidate transverse momentum, unsigned |
| cand_chi2 | input | 8 | Candidate chi-square, unsigned |
| cand_fit_ok | input | 1 | Fitter reports a converged fit |
| region_end | input | 1 | Last cycle of the current region |
| sel_mode | input | 2 | Strategy: 0/3 max momentum, 1 pair by chi-square, 2 min chi-square |
| pt_cut | input | 16 | Momentum threshold for the trigger bit |
| res_vld | output | 1 | Result present |
| res_pt | output | 16 | Chosen momentum |
| res_chi2 | output | 8 | Chosen chi-square |
| res_trig | output | 1 | Chosen momentum reaches the threshold |
| res_none | output | 1 | No qualifying candidate in the region |

## Verification
Two events can land in one cycle: the last candidate of a region can arrive, and the region can close. That candidate must be merged into the result, and the running state must clear for the next region. The bench provokes this by randomly merging the final candidate with `region_end`, and by starting the next region in the cycle right after the close. Every result is compared with a bench model that recomputes the choice from the full candidate list. A leak of stale state or a dropped final candidate then shows up as a wrong momentum, chi-square or no-candidate flag.

// File: rtl/trk_sel_pkg.sv
`timescale 1ns/1ps
package trk_sel_pkg;
  parameter int PT_W  = 16;
  parameter int CHI_W = 8;

  typedef struct packed {
    logic             v;
    logic [PT_W-1:0]  pt;
    logic [CHI_W-1:0] chi;
  } cand_t;

  typedef enum logic [1:0] {
    SEL_MAX_PT  = 2'd0,
    SEL_PAIR    = 2'd1,
    SEL_MIN_CHI = 2'd2,
    SEL_MAX_ALT = 2'd3
  } sel_mode_e;
endpackage

// File: rtl/trk_best_hold.sv
`timescale 1ns/1ps
// Keeps the single best candidate seen so far; BY_PT picks the ordering key.
module trk_best_hold
  import trk_sel_pkg::*;
#(
  parameter bit BY_PT = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  cand_t in_c,
  input  logic  clr,
  output cand_t nxt_c
);
  cand_t q_c;
  logic  take;

  generate
    if (BY_PT) begin : g_pt
      assign take = in_c.v && (!q_c.v || (in_c.pt > q_c.pt));
    end else begin : g_chi
      assign take = in_c.v && (!q_c.v || (in_c.chi < q_c.chi));
    end
  endgenerate

  always_comb begin
    nxt_c = take ? in_c : q_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_c <= '0;
    end else if (clr || take) begin
      q_c <= clr ? cand_t'('0) : nxt_c;
    end
  end
endmodule

// File: rtl/trk_pair_hold.sv
`timescale 1ns/1ps
// Keeps the two lowest chi-square candidates, slot 0 holding the lower.
module trk_pair_hold
  import trk_sel_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  cand_t in_c,
  input  logic  clr,
  output cand_t nxt0,
  output cand_t nxt1
);
  cand_t q0, q1;
  logic  upd;

  always_comb begin
    nxt0 = q0;
    nxt1 = q1;
    upd  = 1'b0;
    if (in_c.v) begin
      if (!q0.v) begin
        nxt0 = in_c;
        upd  = 1'b1;
      end else if (in_c.chi < q0.chi) begin
        nxt1 = q0;
        nxt0 = in_c;
        upd  = 1'b1;
      end else if (!q1.v || (in_c.chi < q1.chi)) begin
        nxt1 = in_c;
        upd  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q0 <= '0;
      q1 <= '0;
    end else if (clr || upd) begin
      q0 <= clr ? cand_t'('0) : nxt0;
      q1 <= clr ? cand_t'('0) : nxt1;
    end
  end
endmodule

// File: rtl/trk_pick.sv
`timescale 1ns/1ps
// Chooses the final candidate by strategy and forms the trigger bit.
module trk_pick
  import trk_sel_pkg::*;
(
  input  logic [1:0]      mode,
  input  cand_t           by_pt,
  input  cand_t           by_chi,
  input  cand_t           pr0,
  input  cand_t           pr1,
  input  logic [PT_W-1:0] cut,
  output cand_t           pick,
  output logic            trig
);
  cand_t pair_pick;

  always_comb begin
    pair_pick = pr0;
    if (pr1.v && (pr1.pt > pr0.pt)) pair_pick = pr1;
  end

  always_comb begin
    unique case (sel_mode_e'(mode))
      SEL_PAIR:    pick = pair_pick;
      SEL_MIN_CHI: pick = by_chi;
      default:     pick = by_pt;
    endcase
    trig = pick.v && (pick.pt >= cut);
  end
endmodule

// File: rtl/trk_cand_sel.sv
`timescale 1ns/1ps
module trk_cand_sel
  import trk_sel_pkg::*;
#(
  parameter int CHI_MAX = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cand_vld,
  input  logic [PT_W-1:0]  cand_pt,
  input  logic [CHI_W-1:0] cand_chi2,
  input  logic             cand_fit_ok,
  input  logic             region_end,
  input  logic [1:0]       sel_mode,
  input  logic [PT_W-1:0]  pt_cut,
  output logic             res_vld,
  output logic [PT_W-1:0]  res_pt,
  output logic [CHI_W-1:0] res_chi2,
  output logic             res_trig,
  output logic             res_none
);
  localparam logic [CHI_W-1:0] CHI_LIM = CHI_W'(CHI_MAX);

  cand_t in_c;
  cand_t best [2];
  cand_t pr0, pr1, pick;
  logic  trig;

  always_comb begin
    in_c.v   = cand_vld && cand_fit_ok && (cand_chi2 <= CHI_LIM);
    in_c.pt  = cand_pt;
    in_c.chi = cand_chi2;
  end

  // slot 0 keyed on momentum, slot 1 keyed on chi-square
  for (genvar g = 0; g < 2; g++) begin : g_best
    trk_best_hold #(.BY_PT(g == 0)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .in_c  (in_c),
      .clr   (region_end),
      .nxt_c (best[g])
    );
  end

  trk_pair_hold u_pair (
    .clk   (clk),
    .rst_n (rst_n),
    .in_c  (in_c),
    .clr   (region_end),
    .nxt0  (pr0),
    .nxt1  (pr1)
  );

  trk_pick u_pick (
    .mode   (sel_mode),
    .by_pt  (best[0]),
    .by_chi (best[1]),
    .pr0    (pr0),
    .pr1    (pr1),
    .cut    (pt_cut),
    .pick   (pick),
    .trig   (trig)
  );

  logic             vld_d;
  logic [PT_W-1:0]  pt_d;
  logic [CHI_W-1:0] chi_d;
  logic             trig_d, none_d;

  always_comb begin
    vld_d  = region_end;
    pt_d   = pick.v ? pick.pt  : '0;
    chi_d  = pick.v ? pick.chi : '0;
    trig_d = trig;
    none_d = !pick.v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld <= 1'b0;
    end else begin
      res_vld <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_pt   <= '0;
      res_chi2 <= '0;
      res_trig <= 1'b0;
      res_none <= 1'b0;
    end else if (region_end) begin
      res_pt   <= pt_d;
      res_chi2 <= chi_d;
      res_trig <= trig_d;
      res_none <= none_d;
    end
  end
endmodule

// File: rtl/trk_cand_sel_chk.sv
`timescale 1ns/1ps
module trk_cand_sel_chk
  import trk_sel_pkg::*;
#(
  parameter int CHI_MAX = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             region_end,
  input logic [PT_W-1:0]  pt_cut,
  input logic             res_vld,
  input logic [PT_W-1:0]  res_pt,
  input logic [CHI_W-1:0] res_chi2,
  input logic             res_trig,
  input logic             res_none
);
  // R6
  res_follows_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    region_end |=> res_vld);

  // R6
  res_only_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !region_end |=> !res_vld);

  // R8
  empty_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_none) |-> (!res_trig && res_pt == '0 && res_chi2 == '0));

  // R7
  trig_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_none) |-> (res_trig == (res_pt >= $past(pt_cut))));

  // R2
  chi_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_none) |-> (int'(res_chi2) <= CHI_MAX));
endmodule

bind trk_cand_sel trk_cand_sel_chk #(.CHI_MAX(CHI_MAX)) u_chk (.*);

// File: tb/trk_cand_sel_test.sv
`timescale 1ns/1ps
module trk_cand_sel_test;
  localparam int CHI_LIM = 40;
  localparam int MAXN    = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cand_vld, cand_fit_ok, region_end;
  logic [15:0] cand_pt, pt_cut;
  logic [7:0]  cand_chi2;
  logic [1:0]  sel_mode;
  logic        res_vld, res_trig, res_none;
  logic [15:0] res_pt;
  logic [7:0]  res_chi2;

  always #4 clk = ~clk;

  trk_cand_sel uut (
    .clk(clk), .rst_n(rst_n), .cand_vld(cand_vld), .cand_pt(cand_pt),
    .cand_chi2(cand_chi2), .cand_fit_ok(cand_fit_ok), .region_end(region_end),
    .sel_mode(sel_mode), .pt_cut(pt_cut), .res_vld(res_vld), .res_pt(res_pt),
    .res_chi2(res_chi2), .res_trig(res_trig), .res_none(res_none)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int c_pt [MAXN];
  int c_chi[MAXN];
  bit c_ok [MAXN];

  bit pending = 0;
  int e_pt, e_chi;
  bit e_trig, e_none;
  string e_tag;

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit qual(input int i);
    return c_ok[i] && (c_chi[i] <= CHI_LIM);
  endfunction

  // returns chosen index or -1
  function automatic int model_pick(input int n, input int mode);
    int s0 = -1, s1 = -1;
    if (mode == 2) begin
      for (int i = 0; i < n; i++)
        if (qual(i) && (s0 < 0 || c_chi[i] < c_chi[s0])) s0 = i;
      return s0;
    end else if (mode == 1) begin
      for (int i = 0; i < n; i++)
        if (qual(i) && (s0 < 0 || c_chi[i] < c_chi[s0])) s0 = i;
      for (int i = 0; i < n; i++)
        if (i != s0 && qual(i) && (s1 < 0 || c_chi[i] < c_chi[s1])) s1 = i;
      if (s1 >= 0 && c_pt[s1] > c_pt[s0]) return s1;
      return s0;
    end
    for (int i = 0; i < n; i++)
      if (qual(i) && (s0 < 0 || c_pt[i] > c_pt[s0])) s0 = i;
    return s0;
  endfunction

  task automatic step();
    @(negedge clk);
    if (pending) begin
      chk(res_vld === 1'b1, {e_tag, " R6 res_vld"}, int'(res_vld), 1);
      chk(res_none === e_none, {e_tag, " R8 res_none"}, int'(res_none), int'(e_none));
      chk(res_pt == e_pt[15:0], {e_tag, " R3/R4/R5 res_pt"}, int'(res_pt), e_pt);
      chk(res_chi2 == e_chi[7:0], {e_tag, " R2 res_chi2"}, int'(res_chi2), e_chi);
      chk(res_trig === e_trig, {e_tag, " R7 res_trig"}, int'(res_trig), int'(e_trig));
      pending = 0;
    end else begin
      chk(res_vld === 1'b0, "R6 idle res_vld", int'(res_vld), 0);
    end
    cand_vld = 0; region_end = 0; cand_fit_ok = 0;
    cand_pt = '0; cand_chi2 = '0;
  endtask

  // R9: merge puts region_end on the last candidate's cycle
  task automatic run_region(input int n, input int mode, input int cut,
                            input bit merge, input string tag);
    int k;
    for (int i = 0; i < n; i++) begin
      step();
      sel_mode = mode[1:0]; pt_cut = cut[15:0];
      cand_vld = 1; cand_pt = c_pt[i][15:0]; cand_chi2 = c_chi[i][7:0];
      cand_fit_ok = c_ok[i];
      region_end = merge && (i == n - 1);
    end
    if (!merge || n == 0) begin
      step();
      sel_mode = mode[1:0]; pt_cut = cut[15:0];
      region_end = 1;
    end
    k = model_pick(n, mode);
    e_none = (k < 0);
    e_pt   = (k < 0) ? 0 : c_pt[k];
    e_chi  = (k < 0) ? 0 : c_chi[k];
    e_trig = (k >= 0) && (e_pt >= cut);
    e_tag  = tag;
    pending = 1;
  endtask

  task automatic set_c(input int i, input int p, input int c, input bit ok);
    c_pt[i] = p; c_chi[i] = c; c_ok[i] = ok;
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; cand_vld = 0; region_end = 0; cand_fit_ok = 0;
    cand_pt = '0; cand_chi2 = '0; sel_mode = '0; pt_cut = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(res_vld === 1'b0, "R1 reset res_vld", int'(res_vld), 0);
    chk(res_trig === 1'b0, "R1 reset res_trig", int'(res_trig), 0);
    chk(res_none === 1'b0, "R1 reset res_none", int'(res_none), 0);

    // R8: empty region
    run_region(0, 0, 0, 0, "R8 empty");
    // R2: all disqualified (bad fit, chi 41)
    set_c(0, 500, 10, 0); set_c(1, 600, 41, 1);
    run_region(2, 0, 0, 1, "R2 all rejected");
    // R2: chi 40 qualifies; R7 cut equal to pt
    set_c(0, 300, 40, 1); set_c(1, 900, 41, 1);
    run_region(2, 0, 300, 1, "R2 chi40 R7 cut equal");
    // R7: cut one above
    set_c(0, 300, 5, 1);
    run_region(1, 2, 301, 0, "R7 cut above");
    // R3 tie on pt, earlier wins (mode 3)
    set_c(0, 70, 20, 1); set_c(1, 70, 3, 1); set_c(2, 10, 1, 1);
    run_region(3, 3, 0, 0, "R3 tie");
    // R4 tie on chi, earlier wins
    set_c(0, 11, 7, 1); set_c(1, 99, 7, 1); set_c(2, 50, 9, 1);
    run_region(3, 2, 0, 1, "R4 tie");
    // R5 single qualifier
    set_c(0, 44, 12, 1); set_c(1, 999, 50, 1);
    run_region(2, 1, 0, 1, "R5 single");
    // R5 higher pt of best two, equal pt picks lower chi
    set_c(0, 100, 30, 1); set_c(1, 200, 5, 1); set_c(2, 150, 10, 1); set_c(3, 900, 35, 1);
    run_region(4, 1, 0, 0, "R5 pair");
    set_c(0, 80, 9, 1); set_c(1, 80, 2, 1);
    run_region(2, 1, 0, 1, "R5 equal pt");

    // random regions, back to back (R9)
    for (int r = 0; r < 300; r++) begin
      int n = $urandom % 12;
      int m = $urandom % 4;
      int cut;
      bit merge = $urandom % 2;
      for (int i = 0; i < n; i++) begin
        int p = (r % 2) ? ($urandom % 8) : ($urandom % 65536);
        set_c(i, p, $urandom % 56, ($urandom % 8) != 0);
      end
      cut = (r % 3 == 0) ? ($urandom % 65536) : ($urandom % 16);
      run_region(n, m, cut, merge, "R9 random");
    end
    step();
    step();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule